// File: doc/BRIEF.md
# Key-Gated Configuration Register Bank

This block is a small memory-mapped bank of four 32-bit words. One word holds a 16-bit software key. The other three hold configuration settings, and all three are write-protected. A write to a protected word lands only while the key word currently holds the value 16'h4758. In every other state the write is dropped without any response, and the word keeps its value. Reads are never gated. Every mapped word can be read back at any time, whatever the state of the key.

Software opens the bank by writing the key value into the key word. It then programs the protected words and closes the bank again by writing any other value. The key word itself is not protected. The stored configuration words also drive dedicated output ports, so that downstream logic can use them directly.

Top module: `cfg_lock_regs`

## Requirements
- R1: After a synchronous active-high reset, all four words read as zero, and the bank is closed.
- R2: The key word stores only bits 15:0 of a write. Its bits 31:16 always read as zero, and only bits 15:0 are compared against the key.
- R3: A write to a protected word while the key word holds 16'h4758 takes effect at the clock edge that samples the write strobe. The new value is visible right after that edge.
- R4: A write to a protected word while the key word holds any other value leaves that word and the other protected words unchanged.
- R5: Writing a value other than 16'h4758 to the key word closes the bank from the next cycle onward.
- R6: Reads of protected words return their stored value whether the bank is open or closed. Read data is combinational from the address.
- R7: The key word accepts writes at all times, including while the bank is closed.
- R8: A read from an unmapped address returns zero, and a write to an unmapped address changes no word.
- R9: The byte addresses are 0x0 for the key, 0x4 for the general word, 0x8 for the timing word and 0xC for the output word. Any address with bits 1:0 non-zero, or at 0x10 or above, is unmapped.
- R10: The ports `gen_cfg`, `tim_cfg` and `out_cfg` always equal the stored general, timing and output words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| gen_cfg | output | 32 | Stored general configuration word |
| tim_cfg | output | 32 | Stored timing configuration word |
| out_cfg | output | 32 | Stored output configuration word |

## Verification
The bench uses the default parameters: an 8-bit byte address, a 16-bit key of 16'h4758, and all reset values at zero. The 8-bit address reaches offsets outside the four-word window (0x10, 0xFC) as well as misaligned offsets next to mapped words (0x02, 0x06). This lets the tests show that aliasing into a real word cannot happen. Keeping the reset values at zero means any protected write that leaks through while the bank is closed shows up against a known value. Writing the key into the upper half of the data shows that only the low 16 bits open the bank.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

    // Word slots inside the bank; index equals byte address bits 3:2.
    typedef enum logic [1:0] {
        SLOT_KEY = 2'd0,
        SLOT_GEN = 2'd1,
        SLOT_TIM = 2'd2,
        SLOT_OUT = 2'd3
    } slot_e;

    typedef struct packed {
        logic  mapped;
        slot_e slot;
    } dec_t;

    localparam int NUM_PROT  = 3;
    localparam int WORD_LSB  = 2;
    localparam int SLOT_BITS = 2;

    function automatic logic slot_is_protected(slot_e s);
        return s != SLOT_KEY;
    endfunction

    function automatic slot_e prot_slot(int idx);
        return slot_e'(idx + 1);
    endfunction

endpackage

// File: rtl/cfg_lock_decode.sv
module cfg_lock_decode
    import cfg_lock_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int TOP_LSB = WORD_LSB + SLOT_BITS;

    always_comb begin
        dec.slot   = slot_e'(addr[TOP_LSB-1:WORD_LSB]);
        dec.mapped = (addr[WORD_LSB-1:0] == '0) && (addr[ADDR_W-1:TOP_LSB] == '0);
    end
endmodule

// File: rtl/cfg_lock_key.sv
module cfg_lock_key #(
    parameter int          KEY_W   = 16,
    parameter logic [KEY_W-1:0] KEY_VAL = 16'h4758
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wdata,
    output logic [KEY_W-1:0] key_q,
    output logic             open_o
);
    always_ff @(posedge clk) begin
        if (rst)        key_q <= '0;
        else if (wr_en) key_q <= wdata;
    end

    assign open_o = (key_q == KEY_VAL);
endmodule

// File: rtl/cfg_lock_slot.sv
module cfg_lock_slot #(
    parameter int              DATA_W  = 32,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= RST_VAL;
        else if (wr_en) q <= wdata;
    end
endmodule

// File: rtl/cfg_lock_regs.sv
module cfg_lock_regs
    import cfg_lock_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int KEY_W  = 16,
    parameter logic [KEY_W-1:0]           KEY_VAL  = 16'h4758,
    parameter logic [NUM_PROT*DATA_W-1:0] PROT_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] gen_cfg,
    output logic [DATA_W-1:0] tim_cfg,
    output logic [DATA_W-1:0] out_cfg
);
    localparam int RSVD_W = DATA_W - KEY_W;

    dec_t              dec;
    logic [KEY_W-1:0]  key_code;
    logic              bank_open;
    logic              key_wr;
    logic [DATA_W-1:0] prot_q [NUM_PROT];

    cfg_lock_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign key_wr = bus_we && dec.mapped && (dec.slot == SLOT_KEY);

    cfg_lock_key #(.KEY_W(KEY_W), .KEY_VAL(KEY_VAL)) u_key (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (key_wr),
        .wdata  (bus_wdata[KEY_W-1:0]),
        .key_q  (key_code),
        .open_o (bank_open)
    );

    for (genvar i = 0; i < NUM_PROT; i++) begin : g_prot
        logic wr_en;
        assign wr_en = bus_we && dec.mapped && bank_open
                    && slot_is_protected(dec.slot)
                    && (dec.slot == prot_slot(i));

        cfg_lock_slot #(
            .DATA_W  (DATA_W),
            .RST_VAL (PROT_RST[i*DATA_W +: DATA_W])
        ) u_slot (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_en),
            .wdata (bus_wdata),
            .q     (prot_q[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (dec.mapped) begin
            case (dec.slot)
                SLOT_KEY: bus_rdata = {{RSVD_W{1'b0}}, key_code};
                SLOT_GEN: bus_rdata = prot_q[0];
                SLOT_TIM: bus_rdata = prot_q[1];
                SLOT_OUT: bus_rdata = prot_q[2];
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign gen_cfg = prot_q[0];
    assign tim_cfg = prot_q[1];
    assign out_cfg = prot_q[2];
endmodule

// File: rtl/cfg_lock_chk.sv
module cfg_lock_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int KEY_W  = 16,
    parameter logic [KEY_W-1:0] KEY_VAL = 16'h4758
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] gen_cfg,
    input logic [DATA_W-1:0] tim_cfg,
    input logic [DATA_W-1:0] out_cfg,
    input logic [KEY_W-1:0]  key_code
);
    logic in_window;
    logic prot_addr;
    assign in_window = (bus_addr < ADDR_W'(16)) && (bus_addr[1:0] == 2'b00);
    assign prot_addr = in_window && (bus_addr != '0);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (key_code == '0 && gen_cfg == '0)); // R1

    AST_OPEN_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(4) && key_code == KEY_VAL)
        |=> gen_cfg == $past(bus_wdata)); // R3

    AST_CLOSED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (bus_we && prot_addr && key_code != KEY_VAL)
        |=> ($stable(gen_cfg) && $stable(tim_cfg) && $stable(out_cfg))); // R4

    AST_KEY_ALWAYS_WRITABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == '0) |=> key_code == $past(bus_wdata[KEY_W-1:0])); // R7

    AST_KEY_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == '0) |-> bus_rdata[DATA_W-1:KEY_W] == '0); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !in_window |-> bus_rdata == '0); // R8

    AST_GEN_READ_MIRRORS: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(4)) |-> bus_rdata == gen_cfg); // R6
endmodule

bind cfg_lock_regs cfg_lock_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .KEY_W  (KEY_W),
    .KEY_VAL(KEY_VAL)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .gen_cfg   (gen_cfg),
    .tim_cfg   (tim_cfg),
    .out_cfg   (out_cfg),
    .key_code  (key_code)
);

// File: tb/test_cfg_lock_regs.sv
`timescale 1ns/1ps
module test_cfg_lock_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, gen_cfg, tim_cfg, out_cfg;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [31:0] KEY = 32'h0000_4758;

    always #5 clk = ~clk;

    cfg_lock_regs i_cfg_lock_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gen_cfg(gen_cfg), .tim_cfg(tim_cfg), .out_cfg(out_cfg)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd_check("R1 key after reset", 8'h00, 32'h0);
        rd_check("R1 gen after reset", 8'h04, 32'h0);
        rd_check("R1 tim after reset", 8'h08, 32'h0);
        rd_check("R1 out after reset", 8'h0C, 32'h0);
        check("R10 gen port after reset", gen_cfg, 32'h0);
    endtask

    task automatic t_closed_drop;
        wr(8'h04, 32'hDEAD_BEEF);
        wr(8'h08, 32'hCAFE_F00D);
        wr(8'h0C, 32'h1234_5678);
        rd_check("R4 gen closed", 8'h04, 32'h0);
        rd_check("R4 tim closed", 8'h08, 32'h0);
        rd_check("R4 out closed", 8'h0C, 32'h0);
    endtask

    task automatic t_open_program;
        wr(8'h00, 32'hABCD_4758);
        rd_check("R2 R7 key upper bits dropped", 8'h00, KEY);
        wr(8'h04, 32'h1111_2222);
        wr(8'h08, 32'h3333_4444);
        wr(8'h0C, 32'h5555_6666);
        rd_check("R3 R9 gen at 0x4", 8'h04, 32'h1111_2222);
        rd_check("R3 R9 tim at 0x8", 8'h08, 32'h3333_4444);
        rd_check("R3 R9 out at 0xC", 8'h0C, 32'h5555_6666);
        check("R10 gen port", gen_cfg, 32'h1111_2222);
        check("R10 tim port", tim_cfg, 32'h3333_4444);
        check("R10 out port", out_cfg, 32'h5555_6666);
    endtask

    task automatic t_timing_edge;
        // value must appear right after the sampling edge
        @(negedge clk);
        bus_addr = 8'h04; bus_wdata = 32'h0BAD_CAFE; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
        check("R3 update after one edge", gen_cfg, 32'h0BAD_CAFE);
        wr(8'h04, 32'h1111_2222);
    endtask

    task automatic t_relock;
        wr(8'h00, 32'h0000_4759);
        rd_check("R7 key rewritten", 8'h00, 32'h0000_4759);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_check("R5 gen kept after relock", 8'h04, 32'h1111_2222);
        rd_check("R5 R6 out readable while closed", 8'h0C, 32'h5555_6666);
    endtask

    task automatic t_key_low_half_only;
        wr(8'h00, 32'h4758_0000);
        rd_check("R2 key low half only", 8'h00, 32'h0);
        wr(8'h08, 32'h7777_7777);
        rd_check("R2 upper-half key does not open", 8'h08, 32'h3333_4444);
    endtask

    task automatic t_unmapped;
        wr(8'h00, KEY);
        rd_check("R8 read 0x10", 8'h10, 32'h0);
        rd_check("R8 R9 read 0x02", 8'h02, 32'h0);
        rd_check("R8 read 0xFC", 8'h FC, 32'h0);
        wr(8'h10, 32'h9999_9999);
        wr(8'h06, 32'h8888_8888);
        wr(8'h01, 32'h0000_0000);
        wr(8'h14, 32'hAAAA_AAAA);
        rd_check("R8 key unchanged", 8'h00, KEY);
        rd_check("R8 gen unchanged", 8'h04, 32'h1111_2222);
        rd_check("R8 tim unchanged", 8'h08, 32'h3333_4444);
        rd_check("R8 out unchanged", 8'h0C, 32'h5555_6666);
    endtask

    initial begin
        t_reset();
        t_closed_drop();
        t_open_program();
        t_timing_edge();
        t_relock();
        t_key_low_half_only();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule